// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits each and returns the full signed product of `2*WIDTH` bits. The multiplier operand is cut into overlapping three-bit windows, and each window becomes one radix-4 digit from the set {-2, -1, 0, +1, +2}. That leaves only `WIDTH/2` partial-product rows, about half the rows of a plain array multiplier. Each row selects zero, the multiplicand or twice the multiplicand. A negative row is made by bitwise inversion plus a carry-in bit at the row's lowest weight. Each row is represented by its inverted sign bit and one shared constant, not by full sign extension. A plain chain of adders sums the rows.

The block suits datapaths that need one signed multiply per cycle without a tree compressor. The parameter `OUT_REG` selects a purely combinational result (0) or one output register stage (1, the default). `WIDTH` must be even and at least 4. A caller with an odd-width operand sign-extends it by one bit first.

Top module: `booth4_mult`

## Requirements
- R1: For every pair of signed inputs, `prod_o` equals the two's-complement product `a_i * b_i`, represented on `2*WIDTH` bits.
- R2: With `OUT_REG=1`, the product of the inputs present at a rising clock edge appears on `prod_o` directly after that edge and stays until the next edge. With `OUT_REG=0`, `prod_o` follows the inputs with no clock.
- R3: With `OUT_REG=1`, `prod_o` reads 0 while `rst_n` is low, whatever the inputs are.
- R4: The most negative value times itself gives +2^(2*WIDTH-2) with no overflow. At WIDTH=8 this is -128 * -128 = 0x4000.
- R5: Each three-bit window (b[2i+1], b[2i], b[2i-1]) is decoded with b[-1]=0, as follows. 000 and 111 select 0. 001 and 010 select +A. 011 selects +2A. 100 selects -2A. 101 and 110 select -A. Multipliers 1, 2, 3, -1, 0x55, 0xAA and -128 each give the correct product.
- R6: A zero in either operand gives a zero product.
- R7: At WIDTH=8, 25 * -35 gives -875, which is 0xFC95.
- R8: While both inputs are held constant, `prod_o` holds the same value on every cycle.
- R9: A product of two nonzero operands has bit 2*WIDTH-1 equal to the XOR of the two operand sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | WIDTH | Signed multiplicand |
| b_i | input | WIDTH | Signed multiplier, Booth-recoded |
| prod_o | output | 2*WIDTH | Signed product |

## Verification
With the default output register, each pair of operands applied between two rising edges is due on `prod_o` right after the next rising edge. For every pair it drives, the bench queues the expected product. A quarter period after each rising edge, it pops one queued item and compares it with `prod_o`, so every product is checked in exactly the cycle it falls due. Held operands queue one identical item per cycle, which checks that the output stays steady. The reset value is sampled while reset is held, before any item is queued.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

    // Control lines of one radix-4 digit
    typedef struct packed {
        logic neg;   // subtract the selected multiple
        logic zero;  // row contributes nothing
        logic two;   // select 2A instead of A
    } bdigit_t;

    // Decode a window {b[2i+1], b[2i], b[2i-1]} into control lines
    function automatic bdigit_t bdecode(input logic [2:0] win);
        bdigit_t d;
        d.zero = (win == 3'b000) || (win == 3'b111);
        d.two  = (win == 3'b011) || (win == 3'b100);
        d.neg  = win[2] & ~d.zero;
        return d;
    endfunction

endpackage

// File: rtl/booth4_enc.sv
module booth4_enc
    import booth4_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]  mplr,
    output bdigit_t           digits [WIDTH/2]
);
    localparam int ROWS = WIDTH / 2;

    for (genvar i = 0; i < ROWS; i++) begin : g_digit
        logic [2:0] win;
        if (i == 0) begin : g_first
            assign win = {mplr[1], mplr[0], 1'b0};
        end else begin : g_rest
            assign win = {mplr[2*i+1], mplr[2*i], mplr[2*i-1]};
        end
        assign digits[i] = bdecode(win);
    end

endmodule

// File: rtl/booth4_row.sv
module booth4_row
    import booth4_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX   = 0
) (
    input  logic [WIDTH-1:0]    mcand,
    input  bdigit_t             dig,
    output logic [2*WIDTH-1:0]  term,
    output logic                corr
);
    localparam int P   = 2 * WIDTH;
    localparam int RW  = WIDTH + 2;     // row width after sign extension
    localparam int SH  = 2 * IDX;       // row weight

    logic [RW-1:0] ax;
    logic [RW-1:0] mult;
    logic [RW-1:0] row;
    logic [RW-1:0] body;

    always_comb begin
        ax   = {{2{mcand[WIDTH-1]}}, mcand};
        if (dig.zero) begin
            mult = '0;
        end else if (dig.two) begin
            mult = {ax[RW-2:0], 1'b0};
        end else begin
            mult = ax;
        end
        row  = dig.neg ? ~mult : mult;
        // low bits of the row plus its inverted sign; the shared bias
        // supplies the remaining weight of the sign
        body = {~row[RW-1], row[RW-2:0]};
        term = {{(P-RW){1'b0}}, body} << SH;
        corr = dig.neg;
    end

endmodule

// File: rtl/booth4_sum.sv
module booth4_sum #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH/2-1:0][2*WIDTH-1:0] terms,
    input  logic [WIDTH/2-1:0]              corr,
    output logic [2*WIDTH-1:0]              total
);
    localparam int P    = 2 * WIDTH;
    localparam int ROWS = WIDTH / 2;

    function automatic logic [P-1:0] calc_bias();
        logic [P-1:0] c;
        c = '0;
        for (int i = 0; i < ROWS; i++) begin
            c = c - (P'(1) << (WIDTH + 1 + 2 * i));
        end
        return c;
    endfunction

    localparam logic [P-1:0] BIAS = calc_bias();

    logic [P-1:0] cvec;
    logic [P-1:0] acc [ROWS+1];

    always_comb begin
        cvec = '0;
        for (int i = 0; i < ROWS; i++) begin
            cvec[2*i] = corr[i];
        end
    end

    assign acc[0] = BIAS + cvec;

    for (genvar i = 0; i < ROWS; i++) begin : g_chain
        assign acc[i+1] = acc[i] + terms[i];
    end

    assign total = acc[ROWS];

endmodule

// File: rtl/booth4_mult.sv
module booth4_mult
    import booth4_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WIDTH-1:0]    a_i,
    input  logic [WIDTH-1:0]    b_i,
    output logic [2*WIDTH-1:0]  prod_o
);
    localparam int P    = 2 * WIDTH;
    localparam int ROWS = WIDTH / 2;

    typedef struct packed {
        logic [P-1:0] prod;
    } pipe_t;

    bdigit_t                   digits [ROWS];
    logic [ROWS-1:0][P-1:0]    terms;
    logic [ROWS-1:0]           corr;
    logic [P-1:0]              sum_w;
    pipe_t                     st_d;

    booth4_enc #(.WIDTH(WIDTH)) u_enc (
        .mplr   (b_i),
        .digits (digits)
    );

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        booth4_row #(.WIDTH(WIDTH), .IDX(i)) u_row (
            .mcand (a_i),
            .dig   (digits[i]),
            .term  (terms[i]),
            .corr  (corr[i])
        );
    end

    booth4_sum #(.WIDTH(WIDTH)) u_sum (
        .terms (terms),
        .corr  (corr),
        .total (sum_w)
    );

    always_comb begin
        st_d      = '0;
        st_d.prod = sum_w;
    end

    if (OUT_REG) begin : g_reg
        pipe_t st_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
        assign prod_o = st_q.prod;
    end else begin : g_comb
        assign prod_o = st_d.prod;
    end

endmodule

// File: rtl/booth4_mult_chk.sv
module booth4_mult_chk #(
    parameter int WIDTH   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WIDTH-1:0]    a_i,
    input  logic [WIDTH-1:0]    b_i,
    input  logic [2*WIDTH-1:0]  prod_o
);
    localparam int P = 2 * WIDTH;
    localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [P-1:0]     MM   = P'(1) << (P - 2);

    logic signed [P-1:0] ref_c;
    logic [P-1:0]        cur_exp;
    logic [WIDTH-1:0]    src_a;
    logic [WIDTH-1:0]    src_b;
    logic                armed;

    assign ref_c = $signed(a_i) * $signed(b_i);

    if (OUT_REG) begin : g_reg
        logic [P-1:0]     exp_q;
        logic [WIDTH-1:0] a_q;
        logic [WIDTH-1:0] b_q;
        logic             armed_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                exp_q   <= '0;
                a_q     <= '0;
                b_q     <= '0;
                armed_q <= 1'b0;
            end else begin
                exp_q   <= ref_c;
                a_q     <= a_i;
                b_q     <= b_i;
                armed_q <= 1'b1;
            end
        end
        assign cur_exp = exp_q;
        assign src_a   = a_q;
        assign src_b   = b_q;
        assign armed   = armed_q;

        a_r3_reset_zero: assert property (@(posedge clk)
            !rst_n |-> prod_o == '0);
    end else begin : g_comb
        assign cur_exp = ref_c;
        assign src_a   = a_i;
        assign src_b   = b_i;
        assign armed   = 1'b1;
    end

    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> prod_o == cur_exp);

    a_r4_min_squared: assert property (@(posedge clk) disable iff (!rst_n)
        armed && src_a == MINV && src_b == MINV |-> prod_o == MM);

    a_r6_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        armed && (src_a == '0 || src_b == '0) |-> prod_o == '0);

    a_r9_sign: assert property (@(posedge clk) disable iff (!rst_n)
        armed && src_a != '0 && src_b != '0
        |-> prod_o[P-1] == (src_a[WIDTH-1] ^ src_b[WIDTH-1]));

endmodule

bind booth4_mult booth4_mult_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_o)
);

// File: tb/booth4_mult_tb.sv
module booth4_mult_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int P = 2 * W;

    typedef struct {
        logic [P-1:0] expv;
        logic [W-1:0] a;
        logic [W-1:0] b;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_r = '0;
    logic [W-1:0] b_r = '0;
    logic [P-1:0] prod_w;

    item_t sb [$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth4_mult #(.WIDTH(W), .OUT_REG(1'b1)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (a_r),
        .b_i    (b_r),
        .prod_o (prod_w)
    );

    function automatic logic [P-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [P-1:0] r;
        r = $signed(a) * $signed(b);
        return r;
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        item_t it;
        @(negedge clk);
        a_r     = a;
        b_r     = b;
        it.expv = model(a, b);
        it.a    = a;
        it.b    = b;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Monitor: one item is due right after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_checks++;
                if (prod_w !== it.expv) begin
                    n_errors++;
                    $display("FAIL %s: a=%0d b=%0d actual=%h expected=%h",
                             it.tag, $signed(it.a), $signed(it.b), prod_w, it.expv);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R3: output cleared while reset is held, with nonzero inputs
        a_r = 8'h55;
        b_r = 8'h33;
        repeat (3) @(negedge clk);
        n_checks++;
        if (prod_w !== '0) begin
            n_errors++;
            $display("FAIL R3: actual=%h expected=%h", prod_w, 16'h0000);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 and R7: first product is due one edge later
        drive(8'd25, -8'sd35, "R2 R7 25*-35");
        // R4
        drive(8'h80, 8'h80, "R4 min*min");
        // R6
        drive(8'd0, -8'sd77, "R6 zero a");
        drive(8'h80, 8'd0, "R6 zero b");
        // R5: multipliers exercising each window code
        drive(-8'sd77, 8'd1,  "R5 b=1");
        drive(-8'sd77, 8'd2,  "R5 b=2");
        drive(8'd113,  8'd3,  "R5 b=3");
        drive(8'd113,  8'hFF, "R5 b=-1");
        drive(-8'sd77, 8'h55, "R5 b=0x55");
        drive(8'd113,  8'hAA, "R5 b=0xAA");
        drive(-8'sd77, 8'h80, "R5 b=-128");
        drive(8'd127,  8'h80, "R5 max*min");
        // R9: sign of nonzero products
        drive(-8'sd3, 8'd5,    "R9 neg*pos");
        drive(8'd7,   -8'sd9,  "R9 pos*neg");
        drive(-8'sd6, -8'sd11, "R9 neg*neg");
        // R8: held inputs keep the same output
        for (int k = 0; k < 4; k++) drive(8'd37, -8'sd41, "R8 hold");

        // R1: exhaustive sweep of all pairs
        for (int i = 0; i < (1 << P); i++) begin
            logic [P-1:0] v;
            v = P'(i);
            drive(v[P-1:W], v[W-1:0], "R1 sweep");
        end

        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule